// File: doc/BRIEF.md
# Trigger Queue Flow-Control State Machine

This block watches the fill level of a trigger queue that holds up to 256 pending events. From that level it derives a one-hot flow-control code for a central trigger throttling system. The code moves between ready, warning and busy with hysteresis, so the level must pass two separate thresholds before the state changes back. The queue storage is outside the block. The block sees only the word count, the full flag and a strobe for each new trigger.

The block also provides two local measures against overflow. The first is a per-event skip bit, captured each time an event header is composed. A set skip bit tells the readout to drop that event's data payload. The second is a flush command, which tells the queue to discard incoming triggers while the block is busy. The block counts consecutive events whose data fragments disagree with the central event number. A long enough run of such events drives the block into out-of-sync. Out-of-sync is also entered when the queue is close to overflow. Only a resynchronisation reset brings the block back to ready. A threshold set that is not in increasing order is flagged and holds the block in ready.

Top module: `tq_throttle`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fmm_code` and `hdr_fmm` read ready (4'b1000), and `skip_bit`, `flush` and `osy_persist` read 0.
- R2: `fmm_code` always has exactly one bit set. The codes are ready 4'b1000, warning 4'b0001, busy 4'b0100 and out-of-sync 4'b0010.
- R3: From ready, a level at or above `warn_hi` moves the state to warning on the next clock edge. From warning, a level below `warn_lo` moves it back to ready. A level in between leaves the state unchanged.
- R4: From ready or warning, a level at or above `busy_hi` moves the state to busy on the next edge. From busy, a level at or below `busy_lo` moves it to warning.
- R5: On each cycle with `hdr_strobe` high, `skip_bit` is loaded with 1 if the level is strictly above `busy_lo` and the configuration is valid, and with 0 otherwise. Between header strobes it holds its value.
- R6: `flush` is high in exactly those cycles where `push` is high and `fmm_code` reads busy.
- R7: From any state other than out-of-sync, a level at or above `osy_hi` or a high `q_full` moves the state to out-of-sync on the next edge.
- R8: A header strobe with `frag_osy` high extends a run of mismatching events. A header strobe with `frag_osy` low clears the run. Cycles without a header strobe leave the run unchanged. The header that completes a run of `RUN_LEN` events moves the state to out-of-sync and sets `osy_persist` on the next edge.
- R9: On each header strobe, `hdr_fmm` captures the `fmm_code` of that cycle. Between header strobes it holds its value.
- R10: Out-of-sync is left only through `resync`. A `resync` pulse returns the state to ready on the next edge and clears both the mismatch run and `osy_persist`.
- R11: `cfg_err` is high whenever the thresholds do not satisfy warn_lo < warn_hi <= busy_lo < busy_hi < osy_hi. While it is high, the state goes to ready from any state other than out-of-sync, and the skip bit loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Resynchronisation reset, one cycle |
| q_level | input | 9 | Queue word count, 0 to 256 |
| q_full | input | 1 | Queue full flag |
| push | input | 1 | New trigger arriving at the queue |
| hdr_strobe | input | 1 | An event header is being composed |
| frag_osy | input | 1 | Fragment event-number mismatch for this header |
| warn_lo | input | 9 | Warning release threshold |
| warn_hi | input | 9 | Warning entry threshold |
| busy_lo | input | 9 | Busy release and skip threshold |
| busy_hi | input | 9 | Busy entry threshold |
| osy_hi | input | 9 | Imminent-overflow threshold |
| fmm_code | output | 4 | One-hot flow-control state |
| hdr_fmm | output | 4 | State code captured at the last header |
| skip_bit | output | 1 | Skip flag for the last header |
| flush | output | 1 | Discard the trigger being pushed |
| osy_persist | output | 1 | Out-of-sync caused by a mismatch run |
| cfg_err | output | 1 | Threshold ordering violated |

## Verification
The assertions assume that `rst_n` behaves as an ordinary reset and that `q_level` never goes above 256. They also assume that every input changes only between clock edges. Changes of the thresholds themselves are not restricted, because the block checks the ordering on every cycle. The stimulus drives inputs shortly after the falling edge and keeps every level within 0 to 256. It uses one valid threshold set for most scenarios and one deliberately invalid set to exercise R11.

// File: rtl/tq_pkg.sv
package tq_pkg;

  typedef enum logic [3:0] {
    FMM_READY = 4'b1000,
    FMM_WARN  = 4'b0001,
    FMM_BUSY  = 4'b0100,
    FMM_OSY   = 4'b0010
  } fmm_e;

  localparam int unsigned N_THR = 5;

endpackage

// File: rtl/tq_cfg_check.sv
module tq_cfg_check #(
  parameter int unsigned CNT_W = 9
) (
  input  logic [CNT_W-1:0] warn_lo,
  input  logic [CNT_W-1:0] warn_hi,
  input  logic [CNT_W-1:0] busy_lo,
  input  logic [CNT_W-1:0] busy_hi,
  input  logic [CNT_W-1:0] osy_hi,
  output logic             cfg_ok
);
  import tq_pkg::*;

  localparam int unsigned N_PAIR = N_THR - 1;
  // bit i set: pair i must be strictly increasing; clear: equal allowed
  localparam logic [N_PAIR-1:0] STRICT = 4'b1101;

  logic [CNT_W-1:0] thr [N_THR];
  logic [N_PAIR-1:0] pair_ok;

  always_comb begin
    thr[0] = warn_lo;
    thr[1] = warn_hi;
    thr[2] = busy_lo;
    thr[3] = busy_hi;
    thr[4] = osy_hi;
  end

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    if (STRICT[i]) begin : g_lt
      assign pair_ok[i] = thr[i] < thr[i+1];
    end else begin : g_le
      assign pair_ok[i] = thr[i] <= thr[i+1];
    end
  end

  assign cfg_ok = &pair_ok;

endmodule

// File: rtl/tq_osy_run.sv
module tq_osy_run #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resync,
  input  logic hdr_strobe,
  input  logic frag_osy,
  input  logic cfg_ok,
  output logic run_hit,
  output logic persist
);
  localparam int unsigned RUN_W = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             run_en;
  logic             pers_d, pers_en;

  assign run_hit = hdr_strobe && frag_osy && (run_q == RUN_LAST);

  always_comb begin
    run_en = resync || hdr_strobe;
    run_d  = run_q;
    if (resync) begin
      run_d = '0;
    end else if (hdr_strobe) begin
      if (!frag_osy) begin
        run_d = '0;
      end else if (run_q != RUN_LAST) begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_comb begin
    pers_en = resync || (run_hit && cfg_ok);
    pers_d  = !resync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      persist <= 1'b0;
    end else begin
      if (run_en)  run_q   <= run_d;
      if (pers_en) persist <= pers_d;
    end
  end

endmodule

// File: rtl/tq_flow_fsm.sv
module tq_flow_fsm #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic [CNT_W-1:0] q_level,
  input  logic             q_full,
  input  logic             push,
  input  logic             hdr_strobe,
  input  logic             cfg_ok,
  input  logic             run_hit,
  input  logic [CNT_W-1:0] warn_lo,
  input  logic [CNT_W-1:0] warn_hi,
  input  logic [CNT_W-1:0] busy_lo,
  input  logic [CNT_W-1:0] busy_hi,
  input  logic [CNT_W-1:0] osy_hi,
  output tq_pkg::fmm_e     state,
  output logic [3:0]       hdr_code,
  output logic             skip,
  output logic             flush
);
  import tq_pkg::*;

  fmm_e state_d;
  logic overflow_near;
  logic skip_d;

  assign overflow_near = q_full || (q_level >= osy_hi);

  always_comb begin
    state_d = state;
    if (resync) begin
      state_d = FMM_READY;
    end else if (state == FMM_OSY) begin
      state_d = FMM_OSY;
    end else if (!cfg_ok) begin
      state_d = FMM_READY;
    end else if (run_hit || overflow_near) begin
      state_d = FMM_OSY;
    end else begin
      unique case (state)
        FMM_READY: begin
          if (q_level >= busy_hi)      state_d = FMM_BUSY;
          else if (q_level >= warn_hi) state_d = FMM_WARN;
        end
        FMM_WARN: begin
          if (q_level >= busy_hi)      state_d = FMM_BUSY;
          else if (q_level < warn_lo)  state_d = FMM_READY;
        end
        FMM_BUSY: begin
          if (q_level <= busy_lo)      state_d = FMM_WARN;
        end
        default: state_d = FMM_READY;
      endcase
    end
  end

  assign skip_d = cfg_ok && (q_level > busy_lo);
  assign flush  = push && (state == FMM_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FMM_READY;
    end else begin
      state <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip     <= 1'b0;
      hdr_code <= FMM_READY;
    end else if (hdr_strobe) begin
      skip     <= skip_d;
      hdr_code <= state;
    end
  end

endmodule

// File: rtl/tq_throttle.sv
module tq_throttle #(
  parameter int unsigned QDEPTH  = 256,
  parameter int unsigned RUN_LEN = 4,
  localparam int unsigned CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic [CNT_W-1:0] q_level,
  input  logic             q_full,
  input  logic             push,
  input  logic             hdr_strobe,
  input  logic             frag_osy,
  input  logic [CNT_W-1:0] warn_lo,
  input  logic [CNT_W-1:0] warn_hi,
  input  logic [CNT_W-1:0] busy_lo,
  input  logic [CNT_W-1:0] busy_hi,
  input  logic [CNT_W-1:0] osy_hi,
  output logic [3:0]       fmm_code,
  output logic [3:0]       hdr_fmm,
  output logic             skip_bit,
  output logic             flush,
  output logic             osy_persist,
  output logic             cfg_err
);
  import tq_pkg::*;

  logic cfg_ok;
  logic run_hit;
  fmm_e state;

  tq_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .warn_lo (warn_lo),
    .warn_hi (warn_hi),
    .busy_lo (busy_lo),
    .busy_hi (busy_hi),
    .osy_hi  (osy_hi),
    .cfg_ok  (cfg_ok)
  );

  tq_osy_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .resync     (resync),
    .hdr_strobe (hdr_strobe),
    .frag_osy   (frag_osy),
    .cfg_ok     (cfg_ok),
    .run_hit    (run_hit),
    .persist    (osy_persist)
  );

  tq_flow_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .resync     (resync),
    .q_level    (q_level),
    .q_full     (q_full),
    .push       (push),
    .hdr_strobe (hdr_strobe),
    .cfg_ok     (cfg_ok),
    .run_hit    (run_hit),
    .warn_lo    (warn_lo),
    .warn_hi    (warn_hi),
    .busy_lo    (busy_lo),
    .busy_hi    (busy_hi),
    .osy_hi     (osy_hi),
    .state      (state),
    .hdr_code   (hdr_fmm),
    .skip       (skip_bit),
    .flush      (flush)
  );

  assign fmm_code = state;
  assign cfg_err  = !cfg_ok;

endmodule

// File: rtl/tq_throttle_chk.sv
module tq_throttle_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resync,
  input logic [CNT_W-1:0] q_level,
  input logic             push,
  input logic             hdr_strobe,
  input logic [CNT_W-1:0] warn_lo,
  input logic [CNT_W-1:0] busy_hi,
  input logic [3:0]       fmm_code,
  input logic [3:0]       hdr_fmm,
  input logic             skip_bit,
  input logic             flush,
  input logic             osy_persist,
  input logic             cfg_err
);
  localparam logic [3:0] C_RDY = 4'b1000;
  localparam logic [3:0] C_WRN = 4'b0001;
  localparam logic [3:0] C_BSY = 4'b0100;
  localparam logic [3:0] C_OSY = 4'b0010;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fmm_code) == 1);

  p_warn_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fmm_code == C_WRN) ##1 (fmm_code == C_RDY) |->
      ($past(q_level) < $past(warn_lo)) || $past(resync) || $past(cfg_err));

  p_busy_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmm_code != C_BSY) ##1 (fmm_code == C_BSY) |->
      $past(q_level) >= $past(busy_hi));

  p_skip_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_strobe |=> $stable(skip_bit));

  p_flush_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> push && (fmm_code == C_BSY));

  p_persist_osy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    osy_persist |-> fmm_code == C_OSY);

  p_hdr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_strobe |=> $stable(hdr_fmm));

  p_osy_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmm_code == C_OSY) && !resync |=> fmm_code == C_OSY);

  p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (fmm_code == C_RDY) && !osy_persist);

  p_cfg_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && (fmm_code != C_OSY) |=> fmm_code == C_RDY);

endmodule

bind tq_throttle tq_throttle_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .resync      (resync),
  .q_level     (q_level),
  .push        (push),
  .hdr_strobe  (hdr_strobe),
  .warn_lo     (warn_lo),
  .busy_hi     (busy_hi),
  .fmm_code    (fmm_code),
  .hdr_fmm     (hdr_fmm),
  .skip_bit    (skip_bit),
  .flush       (flush),
  .osy_persist (osy_persist),
  .cfg_err     (cfg_err)
);

// File: tb/tq_throttle_tb_top.sv
module tq_throttle_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 4;
  localparam logic [3:0] RDY = 4'b1000, WRN = 4'b0001, BSY = 4'b0100, OSY = 4'b0010;

  logic clk = 1'b0;
  logic rst_n;
  logic resync, q_full, push, hdr_strobe, frag_osy;
  logic [8:0] q_level, warn_lo, warn_hi, busy_lo, busy_hi, osy_hi;
  logic [3:0] fmm_code, hdr_fmm;
  logic skip_bit, flush, osy_persist, cfg_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tq_throttle #(.QDEPTH(256), .RUN_LEN(RUN)) dut_i (
    .clk(clk), .rst_n(rst_n), .resync(resync), .q_level(q_level),
    .q_full(q_full), .push(push), .hdr_strobe(hdr_strobe), .frag_osy(frag_osy),
    .warn_lo(warn_lo), .warn_hi(warn_hi), .busy_lo(busy_lo),
    .busy_hi(busy_hi), .osy_hi(osy_hi), .fmm_code(fmm_code), .hdr_fmm(hdr_fmm),
    .skip_bit(skip_bit), .flush(flush), .osy_persist(osy_persist), .cfg_err(cfg_err)
  );

  // ---------------- behavioural reference ----------------
  logic [3:0] m_st, m_hdr;
  int         m_run;
  bit         m_pers, m_skip;

  function automatic bit order_ok();
    int a = warn_lo, b = warn_hi, c = busy_lo, d = busy_hi, e = osy_hi;
    return (a < b) && (b <= c) && (c < d) && (d < e);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= RDY; m_hdr <= RDY; m_run <= 0; m_pers <= 0; m_skip <= 0;
    end else begin
      bit ok;
      bit hit;
      int lvl;
      ok  = order_ok();
      lvl = q_level;
      hit = hdr_strobe && frag_osy && (m_run >= RUN - 1);
      if (hdr_strobe) begin
        m_skip <= ok && (lvl > int'(busy_lo));
        m_hdr  <= m_st;
      end
      if (resync) begin
        m_st <= RDY; m_run <= 0; m_pers <= 0;
      end else begin
        if (hdr_strobe) m_run <= frag_osy ? ((m_run + 1 > RUN - 1) ? RUN - 1 : m_run + 1) : 0;
        if (hit && ok) m_pers <= 1;
        if (m_st == OSY) m_st <= OSY;
        else if (!ok) m_st <= RDY;
        else if (hit || q_full || lvl >= int'(osy_hi)) m_st <= OSY;
        else if (lvl >= int'(busy_hi) && m_st != BSY) m_st <= BSY;
        else if (m_st == RDY && lvl >= int'(warn_hi)) m_st <= WRN;
        else if (m_st == WRN && lvl < int'(warn_lo)) m_st <= RDY;
        else if (m_st == BSY && lvl <= int'(busy_lo)) m_st <= WRN;
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare model and design every clock, before stimulus moves
  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp) begin
      cmp("R2 R3 R4 R7 fmm_code", fmm_code, m_st);
      cmp("R9 hdr_fmm", hdr_fmm, m_hdr);
      cmp("R5 skip_bit", skip_bit, m_skip);
      cmp("R6 flush", flush, push && (m_st == BSY));
      cmp("R8 osy_persist", osy_persist, m_pers);
      cmp("R11 cfg_err", cfg_err, !order_ok());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic hdr(input bit mis);
    hdr_strobe = 1; frag_osy = mis; cyc(1);
    hdr_strobe = 0; frag_osy = 0;
  endtask

  task automatic do_resync();
    resync = 1; cyc(1); resync = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; resync = 0; q_full = 0; push = 0; hdr_strobe = 0; frag_osy = 0;
    q_level = 0; warn_lo = 20; warn_hi = 40; busy_lo = 100; busy_hi = 150; osy_hi = 250;
    cyc(3);
    cmp("R1 reset fmm", fmm_code, RDY);
    cmp("R1 reset flush", flush, 0);
    rst_n = 1;
    cyc(1);
    run_cmp = 1;
    cmp("R1 after reset fmm", fmm_code, RDY);
    cmp("R1 after reset skip", skip_bit, 0);
    cmp("R1 after reset hdr", hdr_fmm, RDY);
    cmp("R1 after reset persist", osy_persist, 0);

    // hysteresis around warning
    q_level = 39; cyc(2);  cmp("R3 below warn_hi", fmm_code, RDY);
    q_level = 40; cyc(1);  cmp("R3 enter warning", fmm_code, WRN);
    q_level = 20; cyc(2);  cmp("R3 hold at warn_lo", fmm_code, WRN);
    q_level = 19; cyc(1);  cmp("R3 back to ready", fmm_code, RDY);

    // busy, flush, skip
    q_level = 150; cyc(1); cmp("R4 enter busy", fmm_code, BSY);
    push = 1; #1; cmp("R6 flush in busy", flush, 1); cyc(1); push = 0;
    q_level = 101; hdr(0);
    cmp("R5 skip above busy_lo", skip_bit, 1);
    cmp("R9 hdr captures busy", hdr_fmm, BSY);
    cyc(3); cmp("R5 skip held", skip_bit, 1);
    q_level = 100; cyc(1); cmp("R4 busy to warning", fmm_code, WRN);
    push = 1; #1; cmp("R6 no flush in warning", flush, 0); cyc(1); push = 0;
    hdr(0); cmp("R5 skip at busy_lo", skip_bit, 0);
    cmp("R9 hdr captures warning", hdr_fmm, WRN);
    q_level = 5; cyc(2); cmp("R3 ready again", fmm_code, RDY);

    // overflow-near entry
    q_level = 250; cyc(1); cmp("R7 level entry", fmm_code, OSY);
    q_level = 0; cyc(5); cmp("R10 sticky", fmm_code, OSY);
    cmp("R8 persist not from level", osy_persist, 0);
    do_resync(); cmp("R10 resync ready", fmm_code, RDY);
    q_full = 1; q_level = 10; cyc(1); cmp("R7 full entry", fmm_code, OSY);
    q_full = 0; do_resync(); cmp("R10 resync again", fmm_code, RDY);

    // mismatch runs
    for (int i = 0; i < RUN - 1; i++) begin hdr(1); cyc(1); end
    hdr(0);
    for (int i = 0; i < RUN - 1; i++) begin hdr(1); cyc(2); end
    cmp("R8 broken run no entry", fmm_code, RDY);
    hdr(1);
    cmp("R8 run entry", fmm_code, OSY);
    cmp("R8 persist set", osy_persist, 1);
    do_resync();
    cmp("R10 persist cleared", osy_persist, 0);
    hdr(1); cmp("R10 run cleared", fmm_code, RDY);
    hdr(0);

    // bad configuration
    warn_hi = 120; q_level = 200; cyc(2);
    cmp("R11 cfg_err", cfg_err, 1);
    cmp("R11 held ready", fmm_code, RDY);
    hdr(0); cmp("R11 no skip", skip_bit, 0);
    warn_hi = 40; cyc(1); cmp("R4 valid again busy", fmm_code, BSY);
    q_level = 0; cyc(3);

    run_cmp = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule